// File: doc/BRIEF.md
# Timebase Counter with Dual Compare Interrupts

This block keeps a 64-bit timebase that advances by one on each cycle in which a tick strobe is high, provided counting is enabled and not held by a debug freeze. Two reference channels each watch the lower 32-bit word of the timebase. When the lower word equals a channel's reference value, that channel's sticky status flag is set. Software clears a flag by writing a 1 to its bit.

An 8-bit interrupt-level output forwards a one-hot priority field whenever a flag is set and that flag's channel is enabled. All configuration goes through one synchronous register port. A write takes effect at the clock edge that samples it, and reads are combinational from the selected register. The reset input is asserted asynchronously and released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Register map (word addresses on `reg_addr`): 0 control/status, 1 timebase lower word, 2 timebase upper word, 3 reference A, 4 reference B. All other addresses read as zero and ignore writes.

Control/status word, bits 15:0 (bits 31:16 read as 0):
- bit 0: count enable
- bit 1: freeze enable
- bit 2: channel A interrupt enable
- bit 3: channel B interrupt enable
- bits 5:4: reserved
- bit 6: flag A (write 1 to clear)
- bit 7: flag B (write 1 to clear)
- bits 15:8: interrupt level

Top module: `tbase_cmp_unit`

## Requirements
- R1: The level field (control bits 15:8) always holds exactly one set bit. Its reset value is 0x80. A control write whose level value does not have exactly one set bit leaves the field unchanged.
- R2: Flag A (bit 6) sets on the clock edge after the lower timebase word equals reference A. Flag B (bit 7) does the same for reference B. References reset to 0xFFFFFFFF.
- R3: Writing 1 to a flag bit of the control word clears that flag. Writing 0 leaves it unchanged.
- R4: `irq_level` equals the level field while (flag A and enable A) or (flag B and enable B) holds. Otherwise it is all zeros.
- R5: With freeze enable (bit 1) at 1, a high `freeze` input stops the timebase. With freeze enable at 0, `freeze` has no effect on counting.
- R6: With count enable (bit 0) at 0, ticks do not advance the timebase. With it at 1, each clock edge that samples `tick` high adds exactly one.
- R7: Control bits 5:4 read as 0 whatever value was written to them.
- R8: The timebase is 64 bits wide. A carry out of the lower word increments the upper word. Each word can be loaded by a write, and a load takes priority over a tick in the same cycle.
- R9: If a match and a write-one-to-clear of the same flag fall in the same cycle, the flag stays set.
- R10: After reset, the control word reads 0x00008000, both timebase words read 0, and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Count strobe |
| freeze | input | 1 | Debug freeze request |
| irq_level | output | 8 | One-hot interrupt level, or zero |

## Verification
- A register write or a tick becomes visible on `reg_rdata` just after the edge that samples it. The bench drives inputs on falling edges and reads one half-cycle after the rising edge.
- A compare flag sets one edge after the lower word reaches the reference value. `irq_level` follows the flag and enable registers with no added delay. The bench therefore waits one extra edge after the counter reaches a reference before checking the flag.
- The same-cycle match-and-clear case is produced by leaving the counter parked on a matching value while the clear is written.

// File: rtl/tbase_cmp_pkg.sv
package tbase_cmp_pkg;
  localparam int TB_W   = 64;
  localparam int WORD_W = 32;
  localparam int LVL_W  = 8;
  localparam int NCH    = 2;
  localparam int AW     = 3;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_TBLO = 3'd1;
  localparam logic [AW-1:0] A_TBHI = 3'd2;
  localparam logic [AW-1:0] A_REFA = 3'd3;
  localparam logic [AW-1:0] A_REFB = 3'd4;

  localparam int B_RUN  = 0;
  localparam int B_FRZ  = 1;
  localparam int B_IEN  = 2;
  localparam int B_FLAG = 6;
  localparam int B_LVL  = 8;

  localparam logic [LVL_W-1:0] LVL_RST = 8'h80;

  typedef struct packed {
    logic             run;
    logic             frz_en;
    logic [NCH-1:0]   ien;
    logic [LVL_W-1:0] level;
  } ctrl_t;
endpackage

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbase_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             run_d,
  input  logic             frz_d,
  input  logic [NCH-1:0]   ien_d,
  input  logic [LVL_W-1:0] lvl_d,
  output ctrl_t            ctrl_q
);
  function automatic int unsigned bitcount(input logic [LVL_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < LVL_W; i++) n += int'(v[i]);
    return n;
  endfunction

  ctrl_t ctrl_n;
  logic  lvl_ok;

  always_comb begin
    lvl_ok = (bitcount(lvl_d) == 1);
    ctrl_n = ctrl_q;
    if (we) begin
      ctrl_n.run    = run_d;
      ctrl_n.frz_en = frz_d;
      ctrl_n.ien    = ien_d;
      if (lvl_ok) ctrl_n.level = lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.run    <= 1'b0;
      ctrl_q.frz_en <= 1'b0;
      ctrl_q.ien    <= '0;
      ctrl_q.level  <= LVL_RST;
    end else if (we) begin
      ctrl_q <= ctrl_n;
    end
  end

  AST_LEVEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_q.level) == 1); // R1
  AST_BAD_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $countones(lvl_d) != 1) |=> $stable(ctrl_q.level)); // R1
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W/2-1:0] ld_val,
  output logic [W-1:0] count_q
);
  localparam int HW = W / 2;

  logic [W-1:0] count_n;
  logic         cnt_ce;

  always_comb begin
    count_n = count_q;
    if (ld_lo || ld_hi) begin
      if (ld_lo) count_n[HW-1:0] = ld_val;
      if (ld_hi) count_n[W-1:HW] = ld_val;
    end else if (step) begin
      count_n = count_q + 1'b1;
    end
    cnt_ce = ld_lo | ld_hi | step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_ce) count_q <= count_n;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> count_q[HW-1:0] == $past(ld_val)); // R8
  AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lo && !ld_hi && &count_q[HW-1:0]) |=>
      count_q[W-1:HW] == $past(count_q[W-1:HW]) + 1'b1); // R8
endmodule

// File: rtl/tbc_chan.sv
module tbc_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_we,
  input  logic [DW-1:0] ref_wdata,
  input  logic [DW-1:0] cur_word,
  input  logic          clr,
  output logic [DW-1:0] ref_q,
  output logic          flag_q
);
  logic hit;
  logic flag_n;

  always_comb begin
    hit    = (cur_word == ref_q);
    flag_n = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (ref_we) ref_q <= ref_wdata;
      flag_q <= flag_n;
    end
  end

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_word == ref_q) |=> flag_q); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R3
  AST_CLR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && cur_word != ref_q) |=> !flag_q); // R3
endmodule

// File: rtl/tbase_cmp_unit.sv
module tbase_cmp_unit
  import tbase_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic              freeze,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int HW = TB_W / 2;

  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  ctrl_t             ctrl_q;
  logic [TB_W-1:0]   tb_q;
  logic [WORD_W-1:0] ref_q  [NCH];
  logic [NCH-1:0]    flag_q;
  logic              we_ctrl, we_lo, we_hi;
  logic [NCH-1:0]    we_ref;
  logic              halted, step;
  logic              irq_any;

  always_comb begin
    we_ctrl = reg_we && (reg_addr == A_CTRL);
    we_lo   = reg_we && (reg_addr == A_TBLO);
    we_hi   = reg_we && (reg_addr == A_TBHI);
    we_ref  = {reg_we && (reg_addr == A_REFB), reg_we && (reg_addr == A_REFA)};
    halted  = ctrl_q.frz_en & freeze;
    step    = tick & ctrl_q.run & ~halted;
  end

  tbc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sn),
    .we     (we_ctrl),
    .run_d  (reg_wdata[B_RUN]),
    .frz_d  (reg_wdata[B_FRZ]),
    .ien_d  (reg_wdata[B_IEN +: NCH]),
    .lvl_d  (reg_wdata[B_LVL +: LVL_W]),
    .ctrl_q (ctrl_q)
  );

  tbc_counter #(.W(TB_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .step    (step),
    .ld_lo   (we_lo),
    .ld_hi   (we_hi),
    .ld_val  (reg_wdata[HW-1:0]),
    .count_q (tb_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tbc_chan #(.DW(WORD_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sn),
      .ref_we    (we_ref[c]),
      .ref_wdata (reg_wdata),
      .cur_word  (tb_q[HW-1:0]),
      .clr       (we_ctrl & reg_wdata[B_FLAG + c]),
      .ref_q     (ref_q[c]),
      .flag_q    (flag_q[c])
    );
  end

  always_comb begin
    irq_any   = |(flag_q & ctrl_q.ien);
    irq_level = irq_any ? ctrl_q.level : '0;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_RUN]             = ctrl_q.run;
        reg_rdata[B_FRZ]             = ctrl_q.frz_en;
        reg_rdata[B_IEN +: NCH]      = ctrl_q.ien;
        reg_rdata[B_FLAG +: NCH]     = flag_q;
        reg_rdata[B_LVL +: LVL_W]    = ctrl_q.level;
      end
      A_TBLO:  reg_rdata = tb_q[HW-1:0];
      A_TBHI:  reg_rdata = tb_q[TB_W-1:HW];
      A_REFA:  reg_rdata = ref_q[0];
      A_REFB:  reg_rdata = ref_q[1];
      default: reg_rdata = '0;
    endcase
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_q.frz_en && freeze && !we_lo && !we_hi) |=> $stable(tb_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ctrl_q.run && !we_lo && !we_hi) |=> $stable(tb_q)); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && ctrl_q.run && !(ctrl_q.frz_en && freeze) && !we_lo && !we_hi)
      |=> tb_q == $past(tb_q) + 1'b1); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_addr == A_CTRL) |-> reg_rdata[5:4] == 2'b00); // R7
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(irq_level)); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    (flag_q == '0) |-> irq_level == '0); // R4
endmodule

// File: tb/tbase_cmp_unit_tb_top.sv
module tbase_cmp_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tick;
  logic        freeze;
  logic [7:0]  irq_level;

  int n_chk;
  int n_bad;
  bit done;

  tbase_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .freeze(freeze), .irq_level(irq_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // ctrl word: level[15:8], flags[7:6], rsvd[5:4], ien[3:2], frz[1], run[0]
  function automatic logic [31:0] cw(input logic [7:0] lvl, input logic [1:0] clrf,
                                     input logic [1:0] ien, input logic frz, input logic run);
    return {16'h0, lvl, clrf, 2'b00, ien, frz, run};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R10", "ctrl after reset", v, 32'h0000_8000);
    rd(3'd1, v); check("R10", "tb lo after reset", v, 0);
    rd(3'd2, v); check("R10", "tb hi after reset", v, 0);
    check("R10", "irq after reset", {24'h0, irq_level}, 0);
    rd(3'd3, v); check("R2", "ref A reset", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'h0000_2000);
    ticks(3);
    rd(3'd1, v); check("R6", "no count while disabled", v, 0);
    wr(3'd0, cw(8'h80, 2'b00, 2'b00, 1'b0, 1'b1));
    ticks(5);
    rd(3'd1, v); check("R6", "five ticks counted", v, 5);
    repeat (4) @(negedge clk);
    rd(3'd1, v); check("R6", "idle cycles do not count", v, 5);
  endtask

  task automatic t_carry;
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_0007);
    ticks(1);
    rd(3'd1, v); check("R8", "lower word wraps", v, 0);
    rd(3'd2, v); check("R8", "carry into upper", v, 8);
    @(negedge clk);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_0040;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    rd(3'd1, v); check("R8", "load beats tick", v, 32'h40);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    wr(3'd1, 0);
    freeze = 1'b1;
    ticks(3);
    rd(3'd1, v); check("R5", "freeze ignored when disabled", v, 3);
    wr(3'd0, cw(8'h80, 2'b00, 2'b00, 1'b1, 1'b1));
    ticks(4);
    rd(3'd1, v); check("R5", "frozen timebase holds", v, 3);
    freeze = 1'b0;
    ticks(2);
    rd(3'd1, v); check("R5", "resumes after freeze", v, 5);
  endtask

  task automatic t_compare;
    logic [31:0] v;
    wr(3'd0, cw(8'h04, 2'b00, 2'b01, 1'b0, 1'b1));
    wr(3'd3, 32'h0000_0100);
    wr(3'd4, 32'h0000_0101);
    wr(3'd1, 32'h0000_00FE);
    rd(3'd0, v); check("R2", "no flag before match", v[7:6], 0);
    check("R4", "no irq before match", {24'h0, irq_level}, 0);
    ticks(2);
    @(negedge clk);
    rd(3'd0, v); check("R2", "flag A set on match", v[7:6], 2'b01);
    check("R4", "irq carries level", {24'h0, irq_level}, 32'h04);
    wr(3'd0, cw(8'h04, 2'b01, 2'b01, 1'b0, 1'b1));
    rd(3'd0, v); check("R9", "clear during match keeps flag", v[7:6], 2'b01);
    ticks(1);
    @(negedge clk);
    rd(3'd0, v); check("R2", "flag B set, A still sticky", v[7:6], 2'b11);
    ticks(1);
    wr(3'd0, cw(8'h04, 2'b00, 2'b01, 1'b0, 1'b1));
    rd(3'd0, v); check("R3", "writing 0 keeps flags", v[7:6], 2'b11);
    wr(3'd0, cw(8'h04, 2'b01, 2'b01, 1'b0, 1'b1));
    rd(3'd0, v); check("R3", "write 1 clears flag A only", v[7:6], 2'b10);
    check("R4", "flag B masked gives no irq", {24'h0, irq_level}, 0);
    wr(3'd0, cw(8'h04, 2'b00, 2'b10, 1'b0, 1'b1));
    check("R4", "enable B raises irq", {24'h0, irq_level}, 32'h04);
    wr(3'd0, cw(8'h04, 2'b10, 2'b10, 1'b0, 1'b1));
    check("R4", "irq drops after clear", {24'h0, irq_level}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(3'd0, cw(8'h06, 2'b00, 2'b00, 1'b0, 1'b0));
    rd(3'd0, v); check("R1", "multi-bit level rejected", v[15:8], 8'h04);
    wr(3'd0, cw(8'h00, 2'b00, 2'b00, 1'b0, 1'b0));
    rd(3'd0, v); check("R1", "zero level rejected", v[15:8], 8'h04);
    wr(3'd0, cw(8'h20, 2'b00, 2'b00, 1'b0, 1'b0) | 32'h30);
    rd(3'd0, v); check("R7", "reserved bits read zero", v[5:4], 0);
    check("R1", "one-hot level accepted", v[15:8], 8'h20);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick = 1'b0; freeze = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_carry();
    t_freeze();
    t_compare();
    t_fields();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule